// File: doc/BRIEF.md
# PCI Target Parity Unit

This block produces and checks the even parity that travels with every phase of a PCI transfer, on behalf of an agent that only ever acts as a target. Every clock it registers the 32-bit address/data lines and the 4-bit command/byte-enable lines, together with a parity bit folded from all 36 of them. In the following clock that stored bit is either driven onto the parity line or compared with the parity the master sent.

The unit drives parity only when the previous clock finished a read data phase that this agent claimed. It compares the incoming parity after two kinds of clock. The first is an address phase, where a mismatch raises a one-clock system-error pulse. The second is a completed write data phase claimed by this agent, where a mismatch raises the data-parity-error line. Both reports appear two clocks after the phase they describe, and each is gated by its own enable input. A sticky flag records every mismatch found, whether or not reporting is enabled.

All bus control inputs are taken in asserted-high form (`1` means the bus signal is active). Decoding, the transfer direction and the claim decision come from neighbouring logic.

Top module: `pci_par_unit`

## Requirements
- R1: When clock k completes a claimed read data phase (`irdy_act`, `trdy_act`, `devsel_act` and `is_read` all 1), then in clock k+1 `par_oe` is 1 and `par_out` equals the XOR of the 32 `ad` bits and 4 `cbe` bits sampled in clock k, so the 37 bits hold an even count of ones.
- R2: `par_oe` is 0 in every clock that does not follow a claimed, completed read data phase. This includes address phases, wait states, writes and unclaimed reads.
- R3: A clock is an address phase when `frame_act` is 1 and the previous clock was idle (`frame_act` and `irdy_act` both 0; the clock before the first clock after reset counts as idle). If `par_in` in the clock after an address phase disagrees with the even parity of that phase, `serr_act` is 1 for exactly one clock, two clocks after the address phase, provided `serr_en` is 1 in the comparison clock.
- R4: If `par_in` in the clock after a completed claimed write data phase disagrees with that phase's even parity, `perr_act` is 1 in the clock two clocks after the data phase, provided `perr_en` is 1 in the comparison clock.
- R5: Parity following a wait state (`irdy_act` and `trdy_act` not both 1) is never checked.
- R6: No `perr_act` is raised for a write data phase during which `devsel_act` was 0.
- R7: Consecutive write data phases with bad parity give `perr_act` high in the same number of consecutive clocks, with none lost or deferred.
- R8: `par_err_seen` becomes 1 on any address or write-data parity mismatch, independently of `perr_en` and `serr_en`, and stays 1 until reset. With an enable at 0 the matching report line stays 0.
- R9: Incoming parity during read transfers is not checked; no `perr_act` results.
- R10: While `rst` is 1 and in the first clock after it falls, all five outputs are 0.
- R11: A clock with `frame_act` 1 that follows a non-idle clock is not an address phase, and a parity mismatch after it raises no `serr_act`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_act | input | 1 | Cycle frame asserted |
| irdy_act | input | 1 | Initiator ready asserted |
| trdy_act | input | 1 | Target ready asserted |
| devsel_act | input | 1 | This agent is claiming the current access |
| is_read | input | 1 | Current transfer moves data from target to master |
| ad | input | 32 | Address/data lines as seen on the bus |
| cbe | input | 4 | Command/byte-enable lines as seen on the bus |
| par_in | input | 1 | Parity line as driven by the master |
| perr_en | input | 1 | Enables data parity error reporting |
| serr_en | input | 1 | Enables address parity error reporting |
| par_out | output | 1 | Parity value to drive |
| par_oe | output | 1 | Drive enable for `par_out` |
| perr_act | output | 1 | Data parity error report, asserted high |
| serr_act | output | 1 | Address parity error pulse, asserted high |
| par_err_seen | output | 1 | Sticky parity mismatch status |

## Verification
A stale or wrong stage register shows up at the ports one or two clocks after the bus phase that loaded it. A bad parity fold corrupts `par_out` in the clock after a read completes. It also produces false or missing `perr_act`/`serr_act` two clocks after a write or address phase. A wrong idle tracker shifts or invents address phases, and that shows as a missing or spurious `serr_act` pulse within three clocks. The bench sweeps all byte-enable codes and several data patterns in both directions with and without injected errors, so every such fault reaches an output within one short transfer.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // One clock of bus history, captured at the edge that ends the clock.
  typedef struct packed {
    logic par;   // even parity of ad and cbe in that clock
    logic addr;  // the clock was an address phase
    logic wr;    // a claimed write data phase completed
    logic rd;    // a claimed read data phase completed
  } stage_t;

  localparam int unsigned STAGE_W = $bits(stage_t);

endpackage

// File: rtl/par_xor_tree.sv
module par_xor_tree #(
  parameter int unsigned W = 36
) (
  input  logic [W-1:0] bits,
  output logic         odd
);

  localparam int unsigned LG = (W > 1) ? $clog2(W) : 1;
  localparam int unsigned N  = 1 << LG;

  logic [N-1:0] fold;

  // Pairwise fold, halving the live width each level: depth is LG XORs.
  always_comb begin
    fold = '0;
    fold[W-1:0] = bits;
    for (int span = N / 2; span >= 1; span = span / 2) begin
      for (int i = 0; i < span; i++) begin
        fold[i] = fold[i] ^ fold[i + span];
      end
    end
    odd = fold[0];
  end

endmodule

// File: rtl/pci_phase_track.sv
module pci_phase_track (
  input  logic clk,
  input  logic rst,
  input  logic frame_act,
  input  logic irdy_act,
  input  logic trdy_act,
  input  logic devsel_act,
  input  logic is_read,
  output logic addr_ph,
  output logic wr_done,
  output logic rd_done
);

  logic idle_q;
  logic xfer;

  // The bus is idle when neither frame nor initiator-ready is active.
  always_ff @(posedge clk) begin
    if (rst) idle_q <= 1'b1;
    else     idle_q <= !frame_act && !irdy_act;
  end

  assign addr_ph = frame_act && idle_q;
  assign xfer    = irdy_act && trdy_act && devsel_act;
  assign wr_done = xfer && !is_read;
  assign rd_done = xfer && is_read;

  // R11: frame stays active after an address phase, so no second one follows
  a_r11_addr_single: assert property (@(posedge clk) disable iff (rst)
    addr_ph |=> !addr_ph);

endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  stage_t stg,
  input  logic   par_in,
  input  logic   perr_en,
  input  logic   serr_en,
  output logic   perr_act,
  output logic   serr_act,
  output logic   par_err_seen
);

  logic mismatch;
  logic addr_bad;
  logic data_bad;

  assign mismatch = stg.par ^ par_in;
  assign addr_bad = stg.addr && mismatch;
  assign data_bad = stg.wr && mismatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_act     <= 1'b0;
      serr_act     <= 1'b0;
      par_err_seen <= 1'b0;
    end else begin
      perr_act     <= data_bad && perr_en;
      serr_act     <= addr_bad && serr_en;
      par_err_seen <= par_err_seen || addr_bad || data_bad;
    end
  end

  // R3: an address error report lasts a single clock
  a_r3_serr_pulse: assert property (@(posedge clk) disable iff (rst)
    serr_act |=> !serr_act);

  // R4: a data error report requires reporting enabled in the compare clock
  a_r4_perr_enabled: assert property (@(posedge clk) disable iff (rst)
    perr_act |-> $past(perr_en));

  // R8: the status flag never clears outside reset
  a_r8_seen_sticky: assert property (@(posedge clk) disable iff (rst)
    par_err_seen |=> par_err_seen);

endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_act,
  input  logic            irdy_act,
  input  logic            trdy_act,
  input  logic            devsel_act,
  input  logic            is_read,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe,
  input  logic            par_in,
  input  logic            perr_en,
  input  logic            serr_en,
  output logic            par_out,
  output logic            par_oe,
  output logic            perr_act,
  output logic            serr_act,
  output logic            par_err_seen
);

  localparam int unsigned COVER_W = AD_W + BE_W;

  logic   addr_ph;
  logic   wr_done;
  logic   rd_done;
  logic   fold_odd;
  stage_t stg_q;

  pci_phase_track u_track (
    .clk       (clk),
    .rst       (rst),
    .frame_act (frame_act),
    .irdy_act  (irdy_act),
    .trdy_act  (trdy_act),
    .devsel_act(devsel_act),
    .is_read   (is_read),
    .addr_ph   (addr_ph),
    .wr_done   (wr_done),
    .rd_done   (rd_done)
  );

  par_xor_tree #(.W(COVER_W)) u_tree (
    .bits({ad, cbe}),
    .odd (fold_odd)
  );

  // Single stage: parity and phase kind of this clock, used in the next.
  always_ff @(posedge clk) begin
    if (rst) stg_q <= '0;
    else     stg_q <= '{par: fold_odd, addr: addr_ph, wr: wr_done, rd: rd_done};
  end

  assign par_out = stg_q.par;
  assign par_oe  = stg_q.rd;

  pci_par_check u_check (
    .clk         (clk),
    .rst         (rst),
    .stg         (stg_q),
    .par_in      (par_in),
    .perr_en     (perr_en),
    .serr_en     (serr_en),
    .perr_act    (perr_act),
    .serr_act    (serr_act),
    .par_err_seen(par_err_seen)
  );

  // R1: drive only in the clock after a claimed read completed
  a_r1_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> $past(irdy_act && trdy_act && devsel_act && is_read));

  // R6: a data error report refers to a claimed, completed write two clocks back
  a_r6_perr_claimed: assert property (@(posedge clk) disable iff (rst)
    perr_act |-> ($past(devsel_act, 2) && $past(irdy_act && trdy_act, 2)
                  && !$past(is_read, 2)));

  // R3: an address error report needs a frame start two clocks back
  a_r3_serr_after_addr: assert property (@(posedge clk) disable iff (rst)
    serr_act |-> $past(frame_act, 2));

endmodule

// File: tb/test_pci_par_unit.sv
module test_pci_par_unit;

  localparam int AD_W = 32;
  localparam int BE_W = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            frame_act = 1'b0, irdy_act = 1'b0, trdy_act = 1'b0;
  logic            devsel_act = 1'b0, is_read = 1'b0;
  logic [AD_W-1:0] ad = '0;
  logic [BE_W-1:0] cbe = '0;
  logic            par_in = 1'b0, perr_en = 1'b1, serr_en = 1'b1;
  logic            par_out, par_oe, perr_act, serr_act, par_err_seen;

  int checks = 0;
  int errors = 0;

  // reference state, built from the requirements
  logic m_idle = 1'b1, m_addr = 1'b0, m_wr = 1'b0, prev_p = 1'b0, exp_seen = 1'b0;

  always #10 clk = ~clk;

  pci_par_unit #(.AD_W(AD_W), .BE_W(BE_W)) i_pci_par_unit (
    .clk(clk), .rst(rst), .frame_act(frame_act), .irdy_act(irdy_act),
    .trdy_act(trdy_act), .devsel_act(devsel_act), .is_read(is_read),
    .ad(ad), .cbe(cbe), .par_in(par_in), .perr_en(perr_en), .serr_en(serr_en),
    .par_out(par_out), .par_oe(par_oe), .perr_act(perr_act),
    .serr_act(serr_act), .par_err_seen(par_err_seen)
  );

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  // One bus clock; inj flips par_in, which covers the previous clock.
  task automatic step(input logic f, input logic i, input logic t, input logic d,
                      input logic r, input logic [AD_W-1:0] a, input logic [BE_W-1:0] c,
                      input logic inj, input string tag);
    logic cur_addr, cur_wr, cur_rd, cur_p, e_serr, e_perr;
    frame_act = f; irdy_act = i; trdy_act = t; devsel_act = d; is_read = r;
    ad = a; cbe = c; par_in = prev_p ^ inj;
    @(posedge clk);
    @(negedge clk);
    cur_addr = f && m_idle;
    cur_wr   = i && t && d && !r;
    cur_rd   = i && t && d && r;
    cur_p    = (($countones({a, c}) % 2) == 1);
    e_serr   = m_addr && inj && serr_en;
    e_perr   = m_wr && inj && perr_en;
    exp_seen = exp_seen || ((m_addr || m_wr) && inj);
    chk(tag, "par_oe", par_oe, cur_rd);
    if (cur_rd) chk(tag, "par_out", par_out, cur_p);
    chk(tag, "serr_act", serr_act, e_serr);
    chk(tag, "perr_act", perr_act, e_perr);
    chk(tag, "par_err_seen", par_err_seen, exp_seen);
    m_idle = !f && !i;
    m_addr = cur_addr;
    m_wr   = cur_wr;
    prev_p = cur_p;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    frame_act = 0; irdy_act = 0; trdy_act = 0; devsel_act = 0; is_read = 0;
    ad = '0; cbe = '0; par_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R10: outputs cleared while held in reset
    chk("R10", "par_oe", par_oe, 1'b0);
    chk("R10", "perr_act", perr_act, 1'b0);
    chk("R10", "serr_act", serr_act, 1'b0);
    chk("R10", "par_err_seen", par_err_seen, 1'b0);
    chk("R10", "par_out", par_out, 1'b0);
    rst = 1'b0;
    m_idle = 1'b1; m_addr = 1'b0; m_wr = 1'b0; prev_p = 1'b0; exp_seen = 1'b0;
  endtask

  // bad_data bit p injects an error on the parity of data phase p
  task automatic txn(input logic rd, input logic dv, input int nph, input int waits,
                     input logic bad_addr, input logic [7:0] bad_data, input logic wait_inj,
                     input logic [AD_W-1:0] base, input logic [BE_W-1:0] cmd,
                     input string tag);
    logic pend;
    step(1'b1, 1'b0, 1'b0, 1'b0, rd, base, cmd, 1'b0, tag);
    pend = bad_addr;
    for (int p = 0; p < nph; p++) begin
      logic last;
      logic [AD_W-1:0] dat;
      logic [BE_W-1:0] be;
      last = (p == nph - 1);
      dat  = base ^ (32'h9E37_79B9 * (p + 1));
      be   = cmd ^ BE_W'(p + 1);
      for (int w = 0; w < waits; w++) begin
        step(!last, 1'b1, 1'b0, dv, rd, dat ^ 32'h0F0F_0000, be, pend, tag);
        pend = wait_inj;
      end
      step(!last, 1'b1, 1'b1, dv, rd, dat, be, pend, tag);
      pend = bad_data[p];
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, pend, tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R10: first clock after reset release
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R10");

    // Sweep: every byte-enable code, several data patterns, both directions,
    // every combination of address and data parity errors (R1, R3, R4, R9).
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 4; k++) begin
        for (int rd = 0; rd < 2; rd++) begin
          for (int bad = 0; bad < 4; bad++) begin
            logic [AD_W-1:0] pat;
            string tg;
            case (k)
              0: pat = 32'h0000_0000;
              1: pat = 32'hFFFF_FFFF;
              2: pat = 32'h1 << (c * 2);
              default: pat = 32'hA5C3_0000 | (c * 32'h0101);
            endcase
            if (bad[0]) tg = "R3";
            else if (rd == 1) tg = bad[1] ? "R9" : "R1";
            else tg = "R4";
            txn(rd[0], 1'b1, 1, 0, bad[0], {7'd0, bad[1]}, 1'b0, pat, c[3:0], tg);
          end
        end
      end
    end

    // R2: unclaimed read and a write never enable the driver
    txn(1'b1, 1'b0, 2, 1, 1'b0, 8'h00, 1'b0, 32'h1234_5678, 4'h6, "R2");
    txn(1'b0, 1'b1, 2, 1, 1'b0, 8'h00, 1'b0, 32'h8765_4321, 4'h7, "R2");

    // R5: errors after wait states only
    txn(1'b0, 1'b1, 3, 2, 1'b0, 8'h00, 1'b1, 32'hDEAD_BEEF, 4'h7, "R5");

    // R6: write not claimed by this agent
    txn(1'b0, 1'b0, 2, 0, 1'b0, 8'h03, 1'b0, 32'hCAFE_F00D, 4'h7, "R6");

    // R7: back-to-back bad write phases
    txn(1'b0, 1'b1, 4, 0, 1'b0, 8'h0F, 1'b0, 32'h0BAD_0BAD, 4'h7, "R7");
    txn(1'b0, 1'b1, 4, 0, 1'b1, 8'h05, 1'b0, 32'h5555_AAAA, 4'h3, "R7");

    // R11: mid-frame clocks carry no address check
    txn(1'b0, 1'b1, 3, 1, 1'b0, 8'h00, 1'b1, 32'h0123_4567, 4'hB, "R11");

    // R8: reporting disabled, status still records
    do_reset();
    perr_en = 1'b0;
    serr_en = 1'b0;
    txn(1'b0, 1'b1, 1, 0, 1'b0, 8'h00, 1'b0, 32'h3333_3333, 4'h7, "R8");
    chk("R8", "par_err_seen clean", par_err_seen, 1'b0);
    txn(1'b0, 1'b1, 2, 0, 1'b1, 8'h03, 1'b0, 32'h7777_1111, 4'h7, "R8");
    chk("R8", "par_err_seen set", par_err_seen, 1'b1);
    perr_en = 1'b1;
    txn(1'b0, 1'b1, 1, 0, 1'b1, 8'h01, 1'b0, 32'h2468_ACE0, 4'h7, "R8");
    serr_en = 1'b1;
    txn(1'b0, 1'b1, 1, 0, 1'b0, 8'h00, 1'b0, 32'h1357_9BDF, 4'h7, "R8");
    chk("R8", "par_err_seen held", par_err_seen, 1'b1);

    // R10: reset clears the sticky flag
    do_reset();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule